// File: doc/BRIEF.md
# Instruction address match interrupt unit

This unit sits beside the fetch/decode stage of a small 16-bit processor with a 20-bit address space. Software loads up to two breakpoint-style match addresses and a per-source enable bit. Each time the decoder presents the start address of the next instruction, the unit compares it against every enabled match register. On a hit it raises a request before that instruction executes. The request cannot be masked: it has no interrupt-enable flag or priority-level input to gate it.

Along with the request the unit reports which source fired and the program-counter value that the CPU should push. That value is deliberately not the true return address. It is the match address advanced by 2 when the decoder classes the instruction as a two-byte opcode or as one of the short one-byte forms with an 8-bit immediate, and by 1 for every other instruction. The handler has to fix up the stack before returning. The request and its fields stay registered until the CPU pulses an acknowledge.

Top module: `amw_match_irq`

## Requirements
- R1: Addresses are compared only in cycles with `dec_valid` high. The decoder asserts `dec_valid` only for the first byte of an instruction. An address presented with `dec_valid` low never raises a request, even if it equals an enabled match register.
- R2: When source i is enabled and `dec_addr` equals match register i in a `dec_valid` cycle, `irq_req` is high from the next clock edge. `irq_src` then gives the source index and `irq_pc` the stacked PC.
- R3: Configuration writes use `cfg_we` with `cfg_sel`. Value 0 loads match register 0 from `cfg_wdata`, and value 1 loads match register 1. Value 2 loads the enable field from `cfg_wdata[1:0]`, where bit i enables source i. A disabled source never raises a request.
- R4: When both sources hit in the same cycle, exactly one request is issued, and `irq_src` is 0.
- R5: `irq_pc` equals the matched address plus 2 for `dec_class` 1 (two-byte opcode) or 2 (listed one-byte short form). It equals the matched address plus 1 for `dec_class` 0 (other) or 3. The sum wraps modulo 2^20.
- R6: Once raised, `irq_req`, `irq_src` and `irq_pc` hold their values until `ack` is seen. Hits presented while the request is pending and not acknowledged are ignored.
- R7: `ack` drops the request at the next edge. A hit presented in the same cycle as `ack` is captured as the new request instead.
- R8: After reset both match registers are zero, both enables are off, and `irq_req`, `irq_src` and `irq_pc` are zero.
- R9: A configuration write affects comparisons from the next cycle on. A decode presented in the same cycle as a write is compared against the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0/1 match register, 2 enable field |
| cfg_wdata | input | 20 | Write data |
| dec_valid | input | 1 | Instruction start address is valid this cycle |
| dec_addr | input | 20 | Start address of the instruction about to execute |
| dec_class | input | 2 | Opcode length class from the decoder |
| ack | input | 1 | CPU acknowledge of the pending request |
| irq_req | output | 1 | Non-maskable address-match request |
| irq_src | output | 1 | Index of the source that fired |
| irq_pc | output | 20 | PC value to push on the stack |

## Verification
The bench builds the unit with its default parameters: two sources and a 20-bit address. With two sources, every combination of enable field, matching-register pattern and opcode class can be swept, 64 cases in all. The hold, ignore and acknowledge behaviour is checked after each raised request. Match addresses at the top of the address space bring the wrap of the stacked PC within reach. Dedicated sequences cover a write that coincides with a decode, an acknowledge that coincides with a new hit, and a matching address presented without the valid strobe.

// File: rtl/amw_pkg.sv
package amw_pkg;

  typedef enum logic [1:0] {
    OPC_OTHER     = 2'd0,
    OPC_WIDE      = 2'd1,
    OPC_SHORT_IMM = 2'd2,
    OPC_RSVD      = 2'd3
  } opc_class_e;

  // Advance applied to the matched address to form the stacked PC.
  function automatic logic [1:0] pc_step(input logic [1:0] cls);
    logic [1:0] step;
    case (opc_class_e'(cls))
      OPC_WIDE, OPC_SHORT_IMM: step = 2'd2;
      default:                 step = 2'd1;
    endcase
    return step;
  endfunction

endpackage

// File: rtl/amw_rst_sync.sv
module amw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/amw_cfg_regs.sv
module amw_cfg_regs #(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 2,
  parameter int SEL_W   = 2
) (
  input  logic                           clk,
  input  logic                           srst_n,
  input  logic                           cfg_we,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr,
  output logic [NUM_SRC-1:0]             match_en
);

  localparam logic [SEL_W-1:0] EN_SEL = SEL_W'(NUM_SRC);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_addr
      logic              wr_hit;
      logic [ADDR_W-1:0] addr_d;
      logic [ADDR_W-1:0] addr_q;

      always_comb begin
        wr_hit = cfg_we && (cfg_sel == SEL_W'(gi));
        addr_d = cfg_wdata;
      end

      always_ff @(posedge clk or negedge srst_n) begin
        if (!srst_n)     addr_q <= '0;
        else if (wr_hit) addr_q <= addr_d;
      end

      assign match_addr[gi] = addr_q;
    end
  endgenerate

  logic               en_wr;
  logic [NUM_SRC-1:0] en_d;
  logic [NUM_SRC-1:0] en_q;

  always_comb begin
    en_wr = cfg_we && (cfg_sel == EN_SEL);
    en_d  = cfg_wdata[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)    en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  assign match_en = en_q;

endmodule

// File: rtl/amw_cmp.sv
module amw_cmp #(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 2
) (
  input  logic                           dec_valid,
  input  logic [ADDR_W-1:0]              dec_addr,
  input  logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr,
  input  logic [NUM_SRC-1:0]             match_en,
  output logic [NUM_SRC-1:0]             hit
);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_cmp
      always_comb begin
        hit[gi] = dec_valid && match_en[gi] && (dec_addr == match_addr[gi]);
      end
    end
  endgenerate

endmodule

// File: rtl/amw_req_hold.sv
module amw_req_hold
  import amw_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 2,
  parameter int SRC_W   = 1
) (
  input  logic               clk,
  input  logic               srst_n,
  input  logic [NUM_SRC-1:0] hit,
  input  logic [ADDR_W-1:0]  dec_addr,
  input  logic [1:0]         dec_class,
  input  logic               ack,
  output logic               irq_req,
  output logic [SRC_W-1:0]   irq_src,
  output logic [ADDR_W-1:0]  irq_pc
);

  logic              req_q, req_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              free;
  logic              any_hit;
  logic              load;
  logic              req_en;
  logic [SRC_W-1:0]  win;

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    win = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) win = SRC_W'(i);
    end
  end

  always_comb begin
    any_hit = |hit;
    free    = !req_q || ack;
    load    = free && any_hit;
    req_en  = free;
    req_d   = any_hit;
    src_d   = win;
    pc_d    = dec_addr + ADDR_W'(pc_step(dec_class));
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     req_q <= 1'b0;
    else if (req_en) req_q <= req_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      src_q <= '0;
      pc_q  <= '0;
    end else if (load) begin
      src_q <= src_d;
      pc_q  <= pc_d;
    end
  end

  assign irq_req = req_q;
  assign irq_src = src_q;
  assign irq_pc  = pc_q;

endmodule

// File: rtl/amw_match_irq.sv
module amw_match_irq #(
  parameter int ADDR_W  = 20,
  parameter int NUM_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [19:0]       cfg_wdata,
  input  logic              dec_valid,
  input  logic [19:0]       dec_addr,
  input  logic [1:0]        dec_class,
  input  logic              ack,
  output logic              irq_req,
  output logic              irq_src,
  output logic [19:0]       irq_pc
);

  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int SEL_W = $clog2(NUM_SRC + 1);

  logic                           srst_n;
  logic [NUM_SRC-1:0][ADDR_W-1:0] match_addr;
  logic [NUM_SRC-1:0]             match_en;
  logic [NUM_SRC-1:0]             hit;
  logic [SRC_W-1:0]               src_w;

  amw_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  amw_cfg_regs #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_cfg (
    .clk        (clk),
    .srst_n     (srst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (SEL_W'(cfg_sel)),
    .cfg_wdata  (ADDR_W'(cfg_wdata)),
    .match_addr (match_addr),
    .match_en   (match_en)
  );

  amw_cmp #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_cmp (
    .dec_valid  (dec_valid),
    .dec_addr   (ADDR_W'(dec_addr)),
    .match_addr (match_addr),
    .match_en   (match_en),
    .hit        (hit)
  );

  logic [ADDR_W-1:0] pc_w;

  amw_req_hold #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_req (
    .clk       (clk),
    .srst_n    (srst_n),
    .hit       (hit),
    .dec_addr  (ADDR_W'(dec_addr)),
    .dec_class (dec_class),
    .ack       (ack),
    .irq_req   (irq_req),
    .irq_src   (src_w),
    .irq_pc    (pc_w)
  );

  assign irq_src = src_w[0];
  assign irq_pc  = 20'(pc_w);

endmodule

// File: rtl/amw_match_irq_chk.sv
module amw_match_irq_chk (
  input logic        clk,
  input logic        srst_n,
  input logic        dec_valid,
  input logic [19:0] dec_addr,
  input logic [1:0]  dec_class,
  input logic        ack,
  input logic        irq_req,
  input logic        irq_src,
  input logic [19:0] irq_pc
);

  // R2: a new request only follows a valid decode
  a_r2_rise_after_valid: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_req) |-> $past(dec_valid));

  // R1: with no valid decode and nothing held, no request appears
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (!dec_valid && (!irq_req || ack)) |=> !irq_req);

  // R5: stacked PC distance from the matched address
  a_r5_pc_step: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq_req) |-> ((irq_pc - $past(dec_addr)) ==
      ((($past(dec_class) == 2'd1) || ($past(dec_class) == 2'd2)) ? 20'd2 : 20'd1)));

  // R6: pending request and its fields hold until acknowledged
  a_r6_hold: assert property (@(posedge clk) disable iff (!srst_n)
    (irq_req && !ack) |=> (irq_req && $stable(irq_pc) && $stable(irq_src)));

  // R7: a request only goes away after an acknowledge
  a_r7_fall_needs_ack: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(irq_req) |-> $past(ack));

endmodule

bind amw_match_irq amw_match_irq_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .dec_valid (dec_valid),
  .dec_addr  (dec_addr),
  .dec_class (dec_class),
  .ack       (ack),
  .irq_req   (irq_req),
  .irq_src   (irq_src),
  .irq_pc    (irq_pc)
);

// File: tb/tb_amw_match_irq.sv
`timescale 1ns/1ps
module tb_amw_match_irq;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [19:0] cfg_wdata;
  logic        dec_valid;
  logic [19:0] dec_addr;
  logic [1:0]  dec_class;
  logic        ack;
  logic        irq_req;
  logic        irq_src;
  logic [19:0] irq_pc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  amw_match_irq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_addr(dec_addr),
    .dec_class(dec_class), .ack(ack), .irq_req(irq_req),
    .irq_src(irq_src), .irq_pc(irq_pc)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [19:0] exp_pc(input logic [19:0] a, input logic [1:0] c);
    return a + ((c == 2'd1 || c == 2'd2) ? 20'd2 : 20'd1);
  endfunction

  // Drive one cycle of inputs at a falling edge, return at the next falling edge.
  task automatic drive(input logic we, input logic [1:0] sel, input logic [19:0] wd,
                       input logic v, input logic [19:0] a, input logic [1:0] c,
                       input logic k);
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    dec_valid = v; dec_addr = a; dec_class = c; ack = k;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [19:0] wd);
    drive(1'b1, sel, wd, 1'b0, 20'd0, 2'd0, 1'b0);
  endtask

  task automatic dec(input logic v, input logic [19:0] a, input logic [1:0] c, input logic k);
    drive(1'b0, 2'd0, 20'd0, v, a, c, k);
  endtask

  task automatic chk(input string tag, input logic req_e, input logic src_e,
                     input logic [19:0] pc_e);
    total++;
    if (irq_req !== req_e ||
        (req_e && (irq_src !== src_e || irq_pc !== pc_e))) begin
      bad++;
      $display("FAIL %s: req=%0b src=%0b pc=%05h expected req=%0b src=%0b pc=%05h",
               tag, irq_req, irq_src, irq_pc, req_e, src_e, pc_e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    dec_valid = 0; dec_addr = 0; dec_class = 0; ack = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8: reset outputs
    total++;
    if (irq_req !== 1'b0 || irq_src !== 1'b0 || irq_pc !== 20'd0) begin
      bad++;
      $display("FAIL R8 reset: req=%0b src=%0b pc=%05h expected 0 0 00000",
               irq_req, irq_src, irq_pc);
    end
    // R8: enables off after reset, so matching address 0 is ignored
    dec(1'b1, 20'd0, 2'd0, 1'b0);
    chk("R8 enables off", 1'b0, 1'b0, 20'd0);
    // R8 / R4: match registers reset to zero, both hit, source 0 wins
    wr(2'd2, 20'd3);
    dec(1'b1, 20'd0, 2'd1, 1'b0);
    chk("R8 R4 zero regs", 1'b1, 1'b0, 20'd2);
    dec(1'b0, 20'd0, 2'd0, 1'b1);
    chk("R7 ack clears", 1'b0, 1'b0, 20'd0);

    // Exhaustive sweep: enable field x matching pattern x class
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 4; c++) begin
          logic [19:0] t;
          logic        req_e;
          logic        src_e;
          logic [1:0]  mk, pt;
          mk = 2'(m); pt = 2'(p);
          t = 20'hFFFFF - 20'(((m * 16 + p * 4 + c) % 3) == 0 ? 0 : (m * 16 + p * 4 + c) * 37);
          wr(2'd0, pt[0] ? t : (t ^ 20'h00100));
          wr(2'd1, pt[1] ? t : (t ^ 20'h00200));
          wr(2'd2, {18'd0, mk});
          req_e = |(mk & pt);
          src_e = !(mk[0] & pt[0]);
          dec(1'b1, t, 2'(c), 1'b0);
          chk("R2 R3 R4 R5 sweep", req_e, src_e, exp_pc(t, 2'(c)));
          if (req_e) begin
            dec(1'b1, t, 2'(c) ^ 2'd1, 1'b0);
            chk("R6 hold ignores new hit", 1'b1, src_e, exp_pc(t, 2'(c)));
            dec(1'b0, t, 2'd0, 1'b0);
            chk("R6 hold idle", 1'b1, src_e, exp_pc(t, 2'(c)));
            dec(1'b0, t, 2'd0, 1'b1);
            chk("R7 ack clears", 1'b0, 1'b0, 20'd0);
          end
        end
      end
    end

    // R5: wrap at top of address space
    wr(2'd0, 20'hFFFFF);
    wr(2'd1, 20'hFFFFE);
    wr(2'd2, 20'd3);
    dec(1'b1, 20'hFFFFF, 2'd2, 1'b0);
    chk("R5 wrap plus 2", 1'b1, 1'b0, 20'h00001);
    // R7: ack together with a new hit loads the new request
    dec(1'b1, 20'hFFFFE, 2'd0, 1'b1);
    chk("R7 ack with new hit", 1'b1, 1'b1, 20'hFFFFF);
    dec(1'b0, 20'd0, 2'd0, 1'b1);
    chk("R7 ack clears", 1'b0, 1'b0, 20'd0);

    // R1: matching address without valid strobe (mid-instruction byte)
    dec(1'b0, 20'hFFFFF, 2'd1, 1'b0);
    chk("R1 no valid no request", 1'b0, 1'b0, 20'd0);
    dec(1'b0, 20'hFFFFE, 2'd0, 1'b0);
    chk("R1 no valid no request", 1'b0, 1'b0, 20'd0);

    // R9: write and decode in the same cycle use the old register value
    drive(1'b1, 2'd0, 20'h12345, 1'b1, 20'h12345, 2'd0, 1'b0);
    chk("R9 same cycle old value", 1'b0, 1'b0, 20'd0);
    dec(1'b1, 20'h12345, 2'd0, 1'b0);
    chk("R9 next cycle new value", 1'b1, 1'b0, 20'h12346);
    dec(1'b0, 20'd0, 2'd0, 1'b1);
    // R9 / R3: disabling in the same cycle as a hit still uses old enables
    drive(1'b1, 2'd2, 20'd0, 1'b1, 20'hFFFFE, 2'd1, 1'b0);
    chk("R9 R3 old enable", 1'b1, 1'b1, 20'h00000);
    dec(1'b0, 20'd0, 2'd0, 1'b1);
    dec(1'b1, 20'hFFFFE, 2'd1, 1'b0);
    chk("R3 disabled no request", 1'b0, 1'b0, 20'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule